// File: doc/BRIEF.md
# Barker-Marker Frame Lock

This block recovers frame timing from a serial bit stream. Every frame is 39 bits long: a 7-bit Barker marker, sent as 1,1,1,0,0,1,0 in order of arrival, followed by 32 payload bits. The block watches the stream for the marker, predicts where the next one should fall, and issues a one-cycle frame-sync pulse at each predicted frame boundary once lock is established.

The block has two lock states. In the seeking state, the first exact marker match re-phases the frame timer, declares lock and fires a sync pulse. In the holding state, the timer's once-per-frame tick drives the sync pulse. A marker that falls on the tick confirms the frame. A tick without a marker counts as one miss, and the pulse still fires so that the receiver keeps running through short fades. Lock is dropped only after five misses in a row. All state advances only on cycles where the bit-valid strobe is high, so the block can sit behind a bit-clock recovery stage that produces one strobe per symbol.

Top module: `frame_lock_top`

## Requirements
- R1: On a cycle with `bit_vld` low, nothing advances. One clock later `fsync_o` and `mark_o` are 0 and `locked_o` is unchanged.
- R2: After a synchronous reset, `fsync_o`, `locked_o` and `mark_o` are 0, the seeking state is active, and the window, timer and miss count are cleared.
- R3: `mark_o` is 1 for one clock, one clock after the strobed bit that completes the marker. The marker counts only if the last seven bits, oldest first, are 1,1,1,0,0,1,0. The bit-reversed sequence is not a match.
- R4: In the seeking state, a marker match sets `locked_o` and fires `fsync_o`, both one clock later. The frame timer is re-phased so that its next tick falls 39 strobed bits after the matching bit.
- R5: In the holding state, the timer ticks every 39 strobed bits. A tick that coincides with a marker match fires `fsync_o` and clears the miss count.
- R6: In the holding state, a tick without a marker match counts one miss. Misses one to four still fire `fsync_o`. The fifth consecutive miss clears `locked_o` and fires no pulse.
- R7: `fsync_o` is never 1 while unlocked, except on the match that establishes lock.
- R8: In the holding state, a marker match that does not coincide with a tick fires no pulse and does not re-phase the timer, but it clears the miss count.
- R9: A marker with any single bit inverted is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new symbol this cycle |
| bit_in | input | 1 | Serial data bit |
| fsync_o | output | 1 | One-cycle frame-sync pulse |
| locked_o | output | 1 | High while in the holding (locked) state |
| mark_o | output | 1 | One-cycle raw marker-match flag |

## Verification
Two functions can fall on the same strobed bit: the timer's frame tick and a marker match. Together they decide confirm, miss or drop. The bench provokes them together by sending marker-headed frames in lock, and apart by sending marker-free frames and by placing a marker in the middle of a payload. A reference model in the bench, written as a phase count and a miss tally, predicts the pulse, the lock flag and the raw match flag for every cycle. The model also judges the fifth miss, which must drop lock without a pulse, and the off-tick marker, which must clear the miss tally without re-phasing.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;

  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_HOLD = 1'b1
  } lock_st_t;

  // Masked equality over the low len bits of two words.
  function automatic logic pattern_eq(input logic [31:0] win,
                                      input logic [31:0] pat,
                                      input int unsigned len);
    logic [31:0] m;
    m = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    return ((win ^ pat) & m) == 32'd0;
  endfunction

  // True when a modulo counter sits on its last value.
  function automatic logic at_wrap(input int unsigned cnt,
                                   input int unsigned period);
    return cnt == period - 1;
  endfunction

  // True when one more miss reaches the limit.
  function automatic logic miss_final(input int unsigned miss,
                                      input int unsigned limit);
    return miss + 1 >= limit;
  endfunction

endpackage

// File: rtl/fl_marker_window.sv
module fl_marker_window #(
  parameter int unsigned MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0] MARKER = 7'b1110010
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit_o
);
  import frame_lock_pkg::*;

  logic [MARK_LEN-1:0] win_q;
  logic [MARK_LEN-1:0] win_d;

  // Oldest bit ends up in the MSB, matching the marker's first symbol.
  assign win_d = {win_q[MARK_LEN-2:0], bit_in};
  assign hit_o = bit_vld && pattern_eq(32'(win_d), 32'(MARKER), MARK_LEN);

  always_ff @(posedge clk) begin
    if (rst)          win_q <= '0;
    else if (bit_vld) win_q <= win_d;
  end
endmodule

// File: rtl/fl_frame_timer.sv
module fl_frame_timer #(
  parameter int unsigned FRAME_LEN = 39
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic rephase_i,
  output logic tick_o
);
  import frame_lock_pkg::*;

  localparam int unsigned CW = $clog2(FRAME_LEN);

  logic [CW-1:0] cnt_q;

  assign tick_o = bit_vld && at_wrap(32'(cnt_q), FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (bit_vld) begin
      if (rephase_i || tick_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/fl_lock_ctrl.sv
module fl_lock_ctrl #(
  parameter int unsigned MISS_LIMIT = 5,
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_vld,
  input  logic          hit_i,
  input  logic          tick_i,
  output logic          rephase_o,
  output logic          fire_o,
  output logic          locked_o,
  output logic [MW-1:0] miss_o
);
  import frame_lock_pkg::*;

  lock_st_t      st_q, st_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    st_d      = st_q;
    miss_d    = miss_q;
    fire_o    = 1'b0;
    rephase_o = 1'b0;
    if (bit_vld) begin
      unique case (st_q)
        ST_SEEK: begin
          if (hit_i) begin
            st_d      = ST_HOLD;
            miss_d    = '0;
            fire_o    = 1'b1;
            rephase_o = 1'b1;
          end
        end
        ST_HOLD: begin
          if (hit_i) miss_d = '0;
          if (tick_i) begin
            if (hit_i) begin
              fire_o = 1'b1;
            end else if (miss_final(32'(miss_q), MISS_LIMIT)) begin
              st_d   = ST_SEEK;
              miss_d = '0;
            end else begin
              miss_d = miss_q + MW'(1);
              fire_o = 1'b1;
            end
          end
        end
        default: st_d = ST_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SEEK;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
    end
  end

  assign locked_o = (st_q == ST_HOLD);
  assign miss_o   = miss_q;
endmodule

// File: rtl/frame_lock_top.sv
module frame_lock_top #(
  parameter int unsigned MARK_LEN   = 7,
  parameter logic [MARK_LEN-1:0] MARKER = 7'b1110010,
  parameter int unsigned FRAME_LEN  = 39,
  parameter int unsigned MISS_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic fsync_o,
  output logic locked_o,
  output logic mark_o
);
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);

  // Internal events, named for the bound checker.
  logic          hit_w;
  logic          tick_w;
  logic          rephase_w;
  logic          fire_w;
  logic [MW-1:0] miss_w;

  fl_marker_window #(.MARK_LEN(MARK_LEN), .MARKER(MARKER)) i_window (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hit_o(hit_w)
  );

  fl_frame_timer #(.FRAME_LEN(FRAME_LEN)) i_timer (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rephase_i(rephase_w),
    .tick_o(tick_w)
  );

  fl_lock_ctrl #(.MISS_LIMIT(MISS_LIMIT)) i_ctrl (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .hit_i(hit_w), .tick_i(tick_w),
    .rephase_o(rephase_w), .fire_o(fire_w), .locked_o(locked_o),
    .miss_o(miss_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_o <= 1'b0;
      mark_o  <= 1'b0;
    end else begin
      fsync_o <= fire_w;
      mark_o  <= hit_w;
    end
  end
endmodule

// File: rtl/frame_lock_chk.sv
module frame_lock_chk #(
  parameter int unsigned MISS_LIMIT = 5,
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_vld,
  input logic          fsync_o,
  input logic          locked_o,
  input logic          mark_o,
  input logic          hit_w,
  input logic          tick_w,
  input logic [MW-1:0] miss_w
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> (!fsync_o && !mark_o && $stable(locked_o))); // R1

  AST_ACQUIRE: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && hit_w) |=> (locked_o && fsync_o)); // R4

  AST_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    (locked_o && tick_w && hit_w) |=> (fsync_o && locked_o && miss_w == '0)); // R5

  AST_DROP_LOCK: assert property (@(posedge clk) disable iff (rst)
    (locked_o && tick_w && !hit_w && miss_w == MW'(MISS_LIMIT - 1))
      |=> (!locked_o && !fsync_o)); // R6

  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    miss_w < MW'(MISS_LIMIT)); // R6

  AST_SYNC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> locked_o); // R7

  AST_OFFTICK_MARK: assert property (@(posedge clk) disable iff (rst)
    (locked_o && hit_w && !tick_w) |=> (!fsync_o && miss_w == '0)); // R8
endmodule

bind frame_lock_top frame_lock_chk #(.MISS_LIMIT(MISS_LIMIT)) i_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .fsync_o(fsync_o),
  .locked_o(locked_o), .mark_o(mark_o), .hit_w(hit_w), .tick_w(tick_w),
  .miss_w(miss_w)
);

// File: tb/test_frame_lock_top.sv
`timescale 1ns/1ps
module test_frame_lock_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic fsync_o, locked_o, mark_o;

  always #2.5 clk = ~clk;

  frame_lock_top i_frame_lock_top (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .fsync_o(fsync_o), .locked_o(locked_o), .mark_o(mark_o)
  );

  typedef struct {
    logic  fs;
    logic  lk;
    logic  mk;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    ready = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R2";

  // Marker in order of arrival.
  int unsigned mk_seq[7] = '{1, 1, 1, 0, 0, 1, 0};

  // Reference model state.
  bit [6:0] m_hist = '0;
  int       m_ph = 0;
  bit       m_lock = 0;
  int       m_miss = 0;

  task automatic step(input bit v, input bit b);
    exp_t e;
    bit det, tick, fs;
    int mism;
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    det = 0; tick = 0; fs = 0;
    if (v) begin
      m_hist = {m_hist[5:0], b};
      mism = 0;
      for (int i = 0; i < 7; i++)
        if (m_hist[6-i] != mk_seq[i][0]) mism++;
      det = (mism == 0);
      m_ph = m_ph + 1;
      if (m_ph == 39) begin tick = 1; m_ph = 0; end
      if (!m_lock) begin
        if (det) begin m_lock = 1; m_miss = 0; m_ph = 0; fs = 1; end
      end else begin
        if (det) m_miss = 0;
        if (tick) begin
          if (det) fs = 1;
          else if (m_miss == 4) begin m_lock = 0; m_miss = 0; end
          else begin m_miss++; fs = 1; end
        end
      end
    end
    e.fs = fs; e.lk = m_lock; e.mk = det; e.req = cur_req;
    sb_q.push_back(e);
  endtask

  task automatic send_marker();
    for (int i = 0; i < 7; i++) step(1, mk_seq[i][0]);
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) step(1, i[0]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // Monitor: compares one expected item per cycle once a stimulus has settled.
  always @(posedge clk) ready <= sb_q.size();

  always @(negedge clk) begin
    if (!rst && ready > 0 && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (fsync_o !== e.fs || locked_o !== e.lk || mark_o !== e.mk) begin
        n_fail++;
        $display("FAIL %s: fsync/locked/mark actual %b%b%b expected %b%b%b at %0t",
                 e.req, fsync_o, locked_o, mark_o, e.fs, e.lk, e.mk, $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1: watchdog expired, actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    n_chk++;
    if (fsync_o !== 1'b0 || locked_o !== 1'b0 || mark_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: reset outputs actual %b%b%b expected 000",
               fsync_o, locked_o, mark_o);
    end
    idle(3);

    cur_req = "R7";                       // no marker: no lock, no pulse
    step(1, 0); step(1, 0); send_data(80);

    cur_req = "R9";                       // each single-bit corruption
    for (int k = 0; k < 7; k++) begin
      for (int i = 0; i < 7; i++) step(1, mk_seq[i][0] ^ (i == k));
      send_data(10);
    end

    cur_req = "R3";                       // reversed order is not a marker
    for (int i = 6; i >= 0; i--) step(1, mk_seq[i][0]);
    send_data(12);

    cur_req = "R4";                       // acquisition
    send_marker();
    cur_req = "R5";                       // confirmed frames
    send_data(32);
    for (int f = 0; f < 3; f++) begin send_marker(); send_data(32); end

    cur_req = "R1";                       // stalls inside a locked frame
    for (int i = 0; i < 7; i++) begin step(1, mk_seq[i][0]); idle(2); end
    for (int i = 0; i < 32; i++) begin step(1, i[0]); if (i % 3 == 0) idle(1); end

    cur_req = "R6";                       // five misses drop lock
    for (int f = 0; f < 6; f++) send_data(39);

    cur_req = "R4";                       // re-acquire
    send_marker(); send_data(32);
    cur_req = "R6";                       // three misses, then confirm
    for (int f = 0; f < 3; f++) send_data(39);
    cur_req = "R5";
    send_marker(); send_data(32);
    cur_req = "R6";                       // four misses keep lock
    for (int f = 0; f < 4; f++) send_data(39);
    cur_req = "R5";
    send_marker(); send_data(32);

    cur_req = "R8";                       // off-tick marker clears the tally
    for (int f = 0; f < 3; f++) send_data(39);
    send_data(10); send_marker(); send_data(22);
    for (int f = 0; f < 4; f++) send_data(39);
    cur_req = "R6";
    send_data(39); send_data(39);
    idle(4);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule